// File: doc/BRIEF.md
# Asynchronous Serial Character Transmitter

This block turns 7-bit characters into asynchronous serial frames. A character is written in parallel into a one-character holding register, which raises a full flag. When transmission is enabled, the block snapshots the character into a shift register and a four-state sequencer walks through ten bit periods. Those periods are one start bit, seven data bits sent least-significant first, one parity bit and one stop/idle period. An external bit-rate tick paces every step. At 1200 bit/s a ten-bit frame lasts about 8.33 ms.

Two commands support starting a message. The initialize command clears the holding register to the NULL code and marks it empty. The header command loads the STX code and marks the register full, so the next enabled tick sends it. The full flag drops as soon as the sequencer reaches the parity step. This lets an upstream buffer refill the register while the current frame is still finishing, so frames can follow each other with no idle gap.

The sequencer states are STOP (idle or stop bit, line at mark), START (start bit), DATA (seven data periods counted by a bit index) and PARITY. The transitions all happen on a bit tick. STOP goes to START when transmit enable and the full flag are both high. START goes to DATA with the bit index at zero. DATA stays in DATA while the index advances, and goes to PARITY after the seventh bit. PARITY goes back to STOP.

Top module: `serial_char_tx`

## Requirements
- R1: One clock after `init_cmd` is high, the holding register holds 0000000 and `hold_full` is 0. This command has priority over every other write.
- R2: One clock after `header_cmd` is high (without `init_cmd`), the holding register holds the STX code 0000010 (hex 02) and `hold_full` is 1.
- R3: `load_valid` stores `load_char` and sets `hold_full` one clock later, but only when `hold_full` is 0. A load while the register is full is ignored and leaves the stored character unchanged.
- R4: A frame starts only on a `bit_tick` clock when the sequencer is idle and both `tx_enable` and `hold_full` are 1. From the next clock, `txd` is 0 for one bit period (the start bit).
- R5: On the next seven ticks, `txd` carries the character's bits 0 to 6, least-significant first, one bit per tick period.
- R6: After the data bits, `txd` carries the parity bit for one bit period. The parity bit is the XOR of the seven data bits, XORed with `odd_parity` (0 selects even parity, 1 selects odd parity).
- R7: `hold_full` is 0 from the clock on which the sequencer enters the parity step, unless a new write arrives on that same edge.
- R8: After the parity bit, `txd` is 1 for at least one bit period (the stop bit). Every state change happens only on a tick. If a character is waiting, the next frame starts on the tick after the stop period, so the frame starts are ten ticks apart.
- R9: After reset, `txd` is 1, `hold_full` is 0 and the sequencer is idle.
- R10: The character is captured when the frame starts. Later changes to the holding register, including an initialize command in mid-frame, do not alter the bits of the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_cmd | input | 1 | Clear the holding register to NULL and mark it empty |
| header_cmd | input | 1 | Load STX into the holding register and mark it full |
| load_valid | input | 1 | Parallel character write strobe |
| load_char | input | 7 | Character to write |
| hold_full | output | 1 | Holding register full flag |
| tx_enable | input | 1 | Permit a frame to start |
| bit_tick | input | 1 | One-clock pulse per bit period |
| odd_parity | input | 1 | Parity sense: 1 odd, 0 even |
| txd | output | 1 | Serial data line, mark (1) when idle |

## Verification
If the bit index or the state is wrong, the fault appears on `txd` within the same frame. A bad index gives a frame that is too short or too long, so the parity and stop bits land in the wrong periods. A bad state holds the line low or skips the start bit, and the monitor sees this on the first misplaced bit period. A wrong full flag shows up as either a missing frame or an extra frame. The extra-frame case appears at the next tick after the faulty flag, because the scoreboard then meets a frame it did not expect. The bench also checks the flag at the last data bit and at the parity bit, and it measures the spacing of back-to-back frame starts, which must be ten ticks. A parity accumulator that misses one bit fails the parity comparison on any character with the right bit pattern. For this reason the bench sends all-ones, all-zeros and alternating patterns under both parity senses.

// File: rtl/serial_tx_pkg.sv
`timescale 1ns/1ps
package serial_tx_pkg;

    // Default character width in bits.
    localparam int CHAR_W_DEF = 7;

    // Sequencer states; DATA covers seven bit periods through an index.
    typedef enum logic [1:0] {
        ST_STOP   = 2'd0,
        ST_START  = 2'd1,
        ST_DATA   = 2'd2,
        ST_PARITY = 2'd3
    } tx_step_e;

endpackage

// File: rtl/char_holding_reg.sv
`timescale 1ns/1ps
module char_holding_reg #(
    parameter int CHAR_W = serial_tx_pkg::CHAR_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              hdr_i,
    input  logic              load_valid_i,
    input  logic [CHAR_W-1:0] load_char_i,
    input  logic              par_clear_i,
    output logic [CHAR_W-1:0] char_o,
    output logic              full_o
);

    localparam logic [CHAR_W-1:0] NULL_CODE = '0;
    localparam logic [CHAR_W-1:0] STX_CODE  = CHAR_W'(2);

    logic [CHAR_W-1:0] char_q, char_d;
    logic              full_q, full_d;

    // Write priority: initialize, header, parallel load, parity-step release.
    always_comb begin
        char_d = char_q;
        full_d = full_q;
        if (init_i) begin
            char_d = NULL_CODE;
            full_d = 1'b0;
        end else if (hdr_i) begin
            char_d = STX_CODE;
            full_d = 1'b1;
        end else if (load_valid_i && !full_q) begin
            char_d = load_char_i;
            full_d = 1'b1;
        end else if (par_clear_i) begin
            full_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            char_q <= NULL_CODE;
            full_q <= 1'b0;
        end else begin
            char_q <= char_d;
            full_q <= full_d;
        end
    end

    assign char_o = char_q;
    assign full_o = full_q;

    // R1: initialize leaves NULL and empty
    assert_init_null_R1: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (char_q == NULL_CODE && !full_q));

    // R2: header leaves STX and full
    assert_header_stx_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_i && !init_i) |=> (char_q == STX_CODE && full_q));

    // R3: a full register keeps its character against plain loads
    assert_load_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !init_i && !hdr_i) |=> $stable(char_q));

endmodule

// File: rtl/tx_step_sequencer.sv
`timescale 1ns/1ps
module tx_step_sequencer #(
    parameter int CHAR_W = serial_tx_pkg::CHAR_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick_i,
    input  logic                    go_i,
    input  logic                    data_bit_i,
    input  logic                    parity_i,
    output logic                    capture_o,
    output logic                    shift_o,
    output logic                    enter_par_o,
    output serial_tx_pkg::tx_step_e step_o,
    output logic                    txd_o
);
    import serial_tx_pkg::*;

    localparam int          IDX_W    = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHAR_W - 1);

    tx_step_e         step_q, step_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= ST_STOP;
            idx_q  <= '0;
        end else begin
            step_q <= step_d;
            idx_q  <= idx_d;
        end
    end

    // Next-state logic: every move waits for a bit tick.
    always_comb begin
        step_d = step_q;
        idx_d  = idx_q;
        unique case (step_q)
            ST_STOP: begin
                if (tick_i && go_i) step_d = ST_START;
            end
            ST_START: begin
                if (tick_i) begin
                    step_d = ST_DATA;
                    idx_d  = '0;
                end
            end
            ST_DATA: begin
                if (tick_i) begin
                    if (idx_q == LAST_IDX) step_d = ST_PARITY;
                    else                   idx_d  = idx_q + 1'b1;
                end
            end
            ST_PARITY: begin
                if (tick_i) step_d = ST_STOP;
            end
            default: step_d = ST_STOP;
        endcase
    end

    // Output logic: strobes for the datapath and the line level.
    always_comb begin
        capture_o   = 1'b0;
        shift_o     = 1'b0;
        enter_par_o = 1'b0;
        txd_o       = 1'b1;
        unique case (step_q)
            ST_STOP: begin
                txd_o     = 1'b1;
                capture_o = tick_i && go_i;
            end
            ST_START: begin
                txd_o = 1'b0;
            end
            ST_DATA: begin
                txd_o       = data_bit_i;
                shift_o     = tick_i;
                enter_par_o = tick_i && (idx_q == LAST_IDX);
            end
            ST_PARITY: begin
                txd_o = parity_i;
            end
            default: txd_o = 1'b1;
        endcase
    end

    assign step_o = step_q;

    // R4: a frame begins only from idle with enable, full and a tick
    assert_start_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == ST_START && $past(step_q) == ST_STOP) |-> $past(go_i && tick_i));

    // R5: the data bit index never passes the last bit
    assert_bit_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == ST_DATA) |-> (idx_q <= LAST_IDX));

    // R8: states change only on bit ticks
    assert_tick_paced_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q != $past(step_q)) |-> $past(tick_i));

endmodule

// File: rtl/frame_shifter.sv
`timescale 1ns/1ps
module frame_shifter #(
    parameter int CHAR_W = serial_tx_pkg::CHAR_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic              shift_i,
    input  logic [CHAR_W-1:0] char_i,
    input  logic              odd_i,
    output logic              data_bit_o,
    output logic              parity_o
);

    logic [CHAR_W-1:0] sh_q;
    logic              acc_q;

    // Snapshot at frame start; shift out LSB first while folding parity.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            acc_q <= 1'b0;
        end else if (capture_i) begin
            sh_q  <= char_i;
            acc_q <= 1'b0;
        end else if (shift_i) begin
            sh_q  <= {1'b0, sh_q[CHAR_W-1:1]};
            acc_q <= acc_q ^ sh_q[0];
        end
    end

    assign data_bit_o = sh_q[0];
    assign parity_o   = acc_q ^ odd_i;

    // R10: the captured character is untouched outside capture and shift
    assert_snapshot_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture_i && !shift_i) |=> $stable(sh_q));

endmodule

// File: rtl/serial_char_tx.sv
`timescale 1ns/1ps
module serial_char_tx #(
    parameter int CHAR_W = serial_tx_pkg::CHAR_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_cmd,
    input  logic              header_cmd,
    input  logic              load_valid,
    input  logic [CHAR_W-1:0] load_char,
    output logic              hold_full,
    input  logic              tx_enable,
    input  logic              bit_tick,
    input  logic              odd_parity,
    output logic              txd
);
    import serial_tx_pkg::*;

    logic [CHAR_W-1:0] held_char;
    logic              capture, shift, enter_par;
    logic              data_bit, parity_bit;
    tx_step_e          step;

    char_holding_reg #(.CHAR_W(CHAR_W)) u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .init_i       (init_cmd),
        .hdr_i        (header_cmd),
        .load_valid_i (load_valid),
        .load_char_i  (load_char),
        .par_clear_i  (enter_par),
        .char_o       (held_char),
        .full_o       (hold_full)
    );

    tx_step_sequencer #(.CHAR_W(CHAR_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (bit_tick),
        .go_i        (tx_enable && hold_full),
        .data_bit_i  (data_bit),
        .parity_i    (parity_bit),
        .capture_o   (capture),
        .shift_o     (shift),
        .enter_par_o (enter_par),
        .step_o      (step),
        .txd_o       (txd)
    );

    frame_shifter #(.CHAR_W(CHAR_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_i  (capture),
        .shift_i    (shift),
        .char_i     (held_char),
        .odd_i      (odd_parity),
        .data_bit_o (data_bit),
        .parity_o   (parity_bit)
    );

    // R7: the full flag is released when the parity step begins
    assert_full_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step == ST_PARITY && $past(step) != ST_PARITY)
            |-> (!hold_full || $past(load_valid) || $past(header_cmd)));

    // R9: the idle/stop step keeps the line at mark
    assert_idle_mark_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step == ST_STOP) |-> txd);

endmodule

// File: tb/test_serial_char_tx.sv
`timescale 1ns/1ps
module test_serial_char_tx;

    localparam int TDIV = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_cmd = 1'b0;
    logic       header_cmd = 1'b0;
    logic       load_valid = 1'b0;
    logic [6:0] load_char = '0;
    logic       tx_enable = 1'b0;
    logic       bit_tick = 1'b0;
    logic       odd_parity = 1'b0;
    logic       hold_full;
    logic       txd;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int tdiv_cnt = 0;
    int tick_no = 0;
    int gap10 = 0;
    // Scoreboard item: {full expected at last data bit, odd parity, character}
    logic [8:0] exp_q[$];

    always #10 clk = ~clk;

    always @(negedge clk) begin
        if (tdiv_cnt == TDIV - 1) begin
            tdiv_cnt <= 0;
            bit_tick <= 1'b1;
        end else begin
            tdiv_cnt <= tdiv_cnt + 1;
            bit_tick <= 1'b0;
        end
    end

    always @(posedge clk) if (bit_tick) tick_no <= tick_no + 1;

    serial_char_tx i_serial_char_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_cmd   (init_cmd),
        .header_cmd (header_cmd),
        .load_valid (load_valid),
        .load_char  (load_char),
        .hold_full  (hold_full),
        .tx_enable  (tx_enable),
        .bit_tick   (bit_tick),
        .odd_parity (odd_parity),
        .txd        (txd)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_tick();
        do @(posedge clk); while (bit_tick !== 1'b1);
        @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Monitor: frame capture and comparison against the scoreboard.
    initial begin : monitor
        logic [9:0] got;
        logic [8:0] e;
        logic       full_d6, full_par, exp_par;
        int         start_tick, prev_start;
        bit         have_prev;
        have_prev = 1'b0;
        prev_start = 0;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (txd === 1'b0) begin
                start_tick = tick_no;
                if (have_prev) begin
                    check((start_tick - prev_start) >= 10, "R8", "frame spacing",
                          start_tick - prev_start, 10);
                    if (start_tick - prev_start == 10) gap10++;
                end
                have_prev  = 1'b1;
                prev_start = start_tick;
                got[0] = txd;
                full_d6 = 1'b0;
                full_par = 1'b0;
                for (int b = 1; b < 10; b++) begin
                    wait_tick();
                    got[b] = txd;
                    if (b == 7) full_d6 = hold_full;
                    if (b == 8) full_par = hold_full;
                end
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4", "unexpected frame", int'(got), 0);
                end else begin
                    e = exp_q.pop_front();
                    exp_par = (^e[6:0]) ^ e[7];
                    check(got[0] == 1'b0, "R4", "start bit", got[0], 0);
                    check(got[7:1] == e[6:0], "R5", "data bits", got[7:1], e[6:0]);
                    check(got[8] == exp_par, "R6", "parity bit", got[8], exp_par);
                    check(got[9] == 1'b1, "R8", "stop bit", got[9], 1);
                    check(full_par == 1'b0, "R7", "full at parity", full_par, 0);
                    check(full_d6 == e[8], "R10", "full at last data bit", full_d6, e[8]);
                end
            end
        end
    end

    // Driver: pushes the expected frame, then writes the character.
    task automatic send(input logic [6:0] ch, input bit midfull);
        @(negedge clk);
        while (hold_full) @(negedge clk);
        exp_q.push_back({midfull, odd_parity, ch});
        load_char  = ch;
        load_valid = 1'b1;
        @(negedge clk);
        load_valid = 1'b0;
        check(hold_full == 1'b1, "R3", "full after load", hold_full, 1);
    endtask

    task automatic wait_quiet();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) wait_tick();
    endtask

    task automatic watch_idle(input int nt, input string req);
        bit low_seen;
        low_seen = 1'b0;
        for (int k = 0; k < nt * TDIV; k++) begin
            @(negedge clk);
            if (txd !== 1'b1) low_seen = 1'b1;
        end
        check(!low_seen, req, "line stays at mark", low_seen, 0);
    endtask

    initial begin : stimulus
        logic [6:0] pats[6];
        pats = '{7'h7F, 7'h00, 7'h55, 7'h2A, 7'h01, 7'h40};

        repeat (4) @(negedge clk);
        check(txd == 1'b1, "R9", "txd in reset", txd, 1);
        check(hold_full == 1'b0, "R9", "full in reset", hold_full, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(txd == 1'b1, "R9", "txd after reset", txd, 1);

        // R1: initialize empties the register; enabled line stays idle
        init_cmd = 1'b1;
        @(negedge clk);
        init_cmd = 1'b0;
        check(hold_full == 1'b0, "R1", "full after init", hold_full, 0);
        tx_enable = 1'b1;
        watch_idle(12, "R1");

        // R2: header sends STX
        exp_q.push_back({1'b1, 1'b0, 7'h02});
        header_cmd = 1'b1;
        @(negedge clk);
        header_cmd = 1'b0;
        check(hold_full == 1'b1, "R2", "full after header", hold_full, 1);
        wait_quiet();

        // R5 R6 R8: back-to-back patterns, even then odd parity
        gap10 = 0;
        foreach (pats[i]) send(pats[i], 1'b1);
        wait_quiet();
        check(gap10 >= 5, "R8", "back-to-back starts ten ticks apart", gap10, 5);
        odd_parity = 1'b1;
        foreach (pats[i]) send(pats[i], 1'b1);
        wait_quiet();
        odd_parity = 1'b0;

        // R4: enable low holds a full register
        tx_enable = 1'b0;
        send(7'h33, 1'b1);
        watch_idle(12, "R4");
        check(hold_full == 1'b1, "R4", "still full while disabled", hold_full, 1);
        tx_enable = 1'b1;
        wait_quiet();

        // R3: a load while full is ignored
        tx_enable = 1'b0;
        send(7'h11, 1'b1);
        load_char  = 7'h6C;
        load_valid = 1'b1;
        @(negedge clk);
        load_valid = 1'b0;
        check(hold_full == 1'b1, "R3", "full after ignored load", hold_full, 1);
        tx_enable = 1'b1;
        wait_quiet();
        watch_idle(12, "R3");

        // R10: initialize in mid-frame does not disturb the frame
        send(7'h5A, 1'b0);
        @(negedge clk);
        while (txd !== 1'b0) @(negedge clk);
        wait_tick();
        wait_tick();
        init_cmd = 1'b1;
        @(negedge clk);
        init_cmd = 1'b0;
        check(hold_full == 1'b0, "R10", "full after mid-frame init", hold_full, 0);
        wait_quiet();
        watch_idle(12, "R10");

        summary();
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
        end
    end

endmodule